// File: doc/BRIEF.md
# Five-Wire Serial Command and Status Port

This block is the device side of a slow serial control link between a line-card processor and a line interface controller. The host drives a serial clock, an active-low chip select and a direction select, and shares one data line with the device. The data line appears here as a separate input, output and output enable, so that the pad cell stays outside the block. When the direction select is low during a frame, the host shifts an 8-bit command into the device, and the device takes the command only when chip select rises. When the direction select is high, the device captures its 5-bit status word as chip select falls and presents it one bit at a time. The host may end a read at any point.

The pad inputs are asynchronous to the system clock, and the serial clock runs at most at 600 kHz. All four pad inputs pass through the same synchronizer chain, which runs on a much faster system clock. Edges of the serial clock and of chip select are found on the synchronized copies, so the whole block runs in one clock domain. Because every pad input has the same delay, their order relative to one another is kept.

Top module: `serial_cmd_port`

## Requirements
- R1: While reset is held, and once it has been released with the pads idle, `cmd_o` reads 0 and `cmd_vld_o`, `sd_o` and `sd_oe_o` read low.
- R2: In a write frame, `sd_i` is sampled on each rising serial clock edge. The first bit sampled ends up in `cmd_o[7]` and the last bit in `cmd_o[0]`.
- R3: A write frame that has exactly 8 rising serial clock edges before chip select rises loads the shifted byte into `cmd_o`. In that same cycle, `cmd_vld_o` pulses high for one system clock cycle.
- R4: A write frame with fewer than 8 rising serial clock edges is dropped. `cmd_o` keeps its previous value and `cmd_vld_o` stays low.
- R5: A write frame with more than 8 rising serial clock edges is dropped in the same way.
- R6: If the direction select goes high at any time while chip select is low in a write frame, the frame is dropped.
- R7: In a read frame, `status_i` is captured when chip select falls. Its bit 4 is presented on `sd_o` first. Each falling serial clock edge moves the next lower bit onto `sd_o`, and 0 follows once all five bits have been shifted out.
- R8: A read that ends after fewer than five bits has no lasting effect. The next read captures `status_i` again and starts over from bit 4.
- R9: `sd_oe_o` is high only while the synchronized chip select is low and the synchronized direction select is high. `sd_o` is low whenever `sd_oe_o` is low.
- R10: With the default two synchronizer stages, a change on a pad input shows at the outputs after the third rising system clock edge that samples it.
- R11: A rising serial clock edge that is seen in the same synchronized sample as the chip select rise still counts as a bit of the write frame.
- R12: A read frame never changes `cmd_o` and never raises `cmd_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select from the host |
| rd_sel_i | input | 1 | Direction select: 0 = host writes a command, 1 = host reads status |
| sd_i | input | 1 | Serial data line as seen at the pad |
| sd_o | output | 1 | Serial data driven toward the pad |
| sd_oe_o | output | 1 | Output enable for the data line pad |
| status_i | input | STS_W (5) | Status word offered to the host |
| cmd_o | output | CMD_W (8) | Last committed command byte |
| cmd_vld_o | output | 1 | One-cycle strobe marking a new command on `cmd_o` |

## Verification
Two things can happen in the same sample: the last rising serial clock edge of a write and the chip select release that closes the frame. The bench causes this by driving both pad inputs to 1 on the same system clock falling edge. The commit must then contain the eighth bit rather than dropping the frame as seven bits short. Every cycle, the reference model compares the outputs it expects for that sample with those of the design. A separate end-of-frame check looks for the exact byte in `cmd_o`.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // positions of the pad signals inside the synchronized vector
  localparam int PAD_SCLK = 0;
  localparam int PAD_CSN  = 1;
  localparam int PAD_RD   = 2;
  localparam int PAD_SDI  = 3;
  localparam int N_PADS   = 4;

  // idle levels: serial clock low, chip select high, write direction, data low
  localparam logic [N_PADS-1:0] PADS_IDLE = 4'b0010;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic clk_rise;
    logic clk_fall;
  } scp_evt_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int               W       = 4,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[STAGES-1];

  // one edge detector per synchronized bit
  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] =  stg_q[STAGES-1][g] & ~stg_q[STAGES][g];
    assign fall_o[g] = ~stg_q[STAGES-1][g] &  stg_q[STAGES][g];
  end
endmodule

// File: rtl/scp_wr.sv
module scp_wr #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  scp_pkg::scp_evt_t evt_i,
  input  logic             csn_s_i,
  input  logic             rd_s_i,
  input  logic             sdi_s_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_vld_o
);
  localparam int             CNT_W   = $clog2(CMD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(CMD_W);

  logic             act_q, act_d;
  logic             bad_q, bad_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CMD_W-1:0] sh_q, sh_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             vld_q, vld_d;
  logic             start;

  assign start = evt_i.cs_fall & ~rd_s_i;

  always_comb begin
    act_d = act_q;
    bad_d = bad_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    cmd_d = cmd_q;
    vld_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      bad_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      if (evt_i.clk_rise) begin
        sh_d = {sh_q[CMD_W-2:0], sdi_s_i};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (!csn_s_i && rd_s_i) bad_d = 1'b1;
      if (evt_i.cs_rise) begin
        act_d = 1'b0;
        if (!bad_d && cnt_d == CNT_OK) begin
          cmd_d = sh_d;
          vld_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      bad_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      act_q <= act_d;
      bad_q <= bad_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      if (act_q) sh_q <= sh_d;
      if (vld_d) cmd_q <= cmd_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign cmd_vld_o = vld_q;
endmodule

// File: rtl/scp_rd.sv
module scp_rd #(
  parameter int STS_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  scp_pkg::scp_evt_t evt_i,
  input  logic              csn_s_i,
  input  logic              rd_s_i,
  input  logic [STS_W-1:0]  status_i,
  output logic              sd_o,
  output logic              sd_oe_o
);
  logic             act_q, act_d;
  logic [STS_W-1:0] sh_q, sh_d;
  logic             oe_q, oe_d;
  logic             sh_en;

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    if (evt_i.cs_fall && rd_s_i) begin
      act_d = 1'b1;
      sh_d  = status_i;
    end else if (act_q) begin
      if (evt_i.cs_rise) act_d = 1'b0;
      else if (evt_i.clk_fall) sh_d = {sh_q[STS_W-2:0], 1'b0};
    end
    oe_d = ~csn_s_i & rd_s_i;
  end

  assign sh_en = (evt_i.cs_fall & rd_s_i) | (act_q & evt_i.clk_fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      oe_q  <= oe_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign sd_o    = sh_q[STS_W-1] & oe_q;
  assign sd_oe_o = oe_q;
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port #(
  parameter int CMD_W       = 8,
  parameter int STS_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             rd_sel_i,
  input  logic             sd_i,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic [STS_W-1:0] status_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_vld_o
);
  import scp_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [N_PADS-1:0] pads, pads_s, pads_rise, pads_fall;
  scp_evt_t          evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    pads           = '0;
    pads[PAD_SCLK] = sclk_i;
    pads[PAD_CSN]  = csn_i;
    pads[PAD_RD]   = rd_sel_i;
    pads[PAD_SDI]  = sd_i;
  end

  scp_sync #(
    .W       (N_PADS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PADS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (pads),
    .q_o    (pads_s),
    .rise_o (pads_rise),
    .fall_o (pads_fall)
  );

  always_comb begin
    evt.cs_fall  = pads_fall[PAD_CSN];
    evt.cs_rise  = pads_rise[PAD_CSN];
    evt.clk_rise = pads_rise[PAD_SCLK];
    evt.clk_fall = pads_fall[PAD_SCLK];
  end

  scp_wr #(.CMD_W(CMD_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .evt_i     (evt),
    .csn_s_i   (pads_s[PAD_CSN]),
    .rd_s_i    (pads_s[PAD_RD]),
    .sdi_s_i   (pads_s[PAD_SDI]),
    .cmd_o     (cmd_o),
    .cmd_vld_o (cmd_vld_o)
  );

  scp_rd #(.STS_W(STS_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .evt_i    (evt),
    .csn_s_i  (pads_s[PAD_CSN]),
    .rd_s_i   (pads_s[PAD_RD]),
    .status_i (status_i),
    .sd_o     (sd_o),
    .sd_oe_o  (sd_oe_o)
  );

  // unused rise/fall bits of direction and data are intentionally dropped
  logic unused_edges;
  assign unused_edges = ^{pads_rise[PAD_RD], pads_rise[PAD_SDI],
                          pads_fall[PAD_RD], pads_fall[PAD_SDI], pads_s[PAD_SCLK]};
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_i,
  input logic             rd_sel_i,
  input logic             sd_o,
  input logic             sd_oe_o,
  input logic [CMD_W-1:0] cmd_o,
  input logic             cmd_vld_o
);
  // cycles since reset, saturating, so history-based checks wait for enough samples
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  p_sd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o |-> !sd_o);

  p_oe_follows_pads_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd4) |-> (sd_oe_o == ($past(!csn_i, 3) && $past(rd_sel_i, 3))));

  p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);

  p_cmd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_o |-> $stable(cmd_o));

  p_commit_on_cs_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && age_q >= 3'd5) |-> ($past(csn_i, 3) && !$past(csn_i, 4)));

  p_no_commit_in_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> !sd_oe_o);
endmodule

bind serial_cmd_port scp_chk #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/tb_serial_cmd_port.sv
module tb_serial_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int HD         = LAT + 2;
  localparam int H          = 4;
  localparam int WD_LIMIT   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, rd = 1'b0, sdi = 1'b0;
  logic [4:0] status = '0;
  logic       sd_o, sd_oe;
  logic [7:0] cmd;
  logic       cmd_vld;

  int checks = 0, errors = 0, cycles = 0, vld_seen = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .rd_sel_i(rd),
    .sd_i(sdi), .sd_o(sd_o), .sd_oe_o(sd_oe), .status_i(status),
    .cmd_o(cmd), .cmd_vld_o(cmd_vld)
  );

  // ---------------- behavioural reference model ----------------
  logic h_csn [HD], h_sclk [HD], h_rd [HD], h_sdi [HD];
  logic [7:0] m_cmd, m_word;
  logic [4:0] m_rsh;
  logic m_vld, m_oe, m_wact, m_bad, m_ract;
  int   m_wn;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HD; i++) begin
        h_csn[i] = 1'b1; h_sclk[i] = 1'b0; h_rd[i] = 1'b0; h_sdi[i] = 1'b0;
      end
      m_cmd = '0; m_word = '0; m_rsh = '0; m_vld = 0; m_oe = 0;
      m_wact = 0; m_bad = 0; m_ract = 0; m_wn = 0;
    end else begin
      for (int i = HD-1; i > 0; i--) begin
        h_csn[i] = h_csn[i-1]; h_sclk[i] = h_sclk[i-1];
        h_rd[i] = h_rd[i-1]; h_sdi[i] = h_sdi[i-1];
      end
      h_csn[0] = csn; h_sclk[0] = sclk; h_rd[0] = rd; h_sdi[0] = sdi;
      m_vld = 0;
      if (h_csn[LAT+1] && !h_csn[LAT]) begin
        if (h_rd[LAT]) begin m_rsh = status; m_ract = 1; end
        else begin m_wact = 1; m_bad = 0; m_wn = 0; end
      end else begin
        if (m_wact) begin
          if (h_sclk[LAT] && !h_sclk[LAT+1]) begin
            m_word = {m_word[6:0], h_sdi[LAT]};
            if (m_wn < 15) m_wn++;
          end
          if (!h_csn[LAT] && h_rd[LAT]) m_bad = 1;
          if (h_csn[LAT] && !h_csn[LAT+1]) begin
            m_wact = 0;
            if (!m_bad && m_wn == 8) begin m_cmd = m_word; m_vld = 1; end
          end
        end
        if (m_ract) begin
          if (h_csn[LAT] && !h_csn[LAT+1]) m_ract = 0;
          else if (!h_sclk[LAT] && h_sclk[LAT+1]) m_rsh = {m_rsh[3:0], 1'b0};
        end
      end
      m_oe = !h_csn[LAT] && h_rd[LAT];
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (cmd !== m_cmd) begin errors++; $display("FAIL R3 cmd_o act=%h exp=%h t=%0t", cmd, m_cmd, $time); end
      if (cmd_vld !== m_vld) begin errors++; $display("FAIL R3 cmd_vld_o act=%b exp=%b t=%0t", cmd_vld, m_vld, $time); end
      if (sd_oe !== m_oe) begin errors++; $display("FAIL R9 sd_oe_o act=%b exp=%b t=%0t", sd_oe, m_oe, $time); end
      if (sd_o !== (m_oe & m_rsh[4])) begin errors++; $display("FAIL R7 sd_o act=%b exp=%b t=%0t", sd_o, m_oe & m_rsh[4], $time); end
      if (cmd_vld === 1'b1) vld_seen++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // write frame: nbits clocks, MSB of data first; flip raises direction mid-frame;
  // merge raises chip select together with the last serial clock edge
  task automatic wr_frame(input logic [8:0] data, input int nbits, input bit flip, input bit merge);
    csn = 1'b0; rd = 1'b0;
    cyc(H);
    check("R9 oe low in write frame", {7'b0, sd_oe}, 8'h00);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      cyc(H);
      sclk = 1'b1;
      if (merge && i == 0) csn = 1'b1;
      cyc(H);
      sclk = 1'b0;
      if (flip && i == nbits / 2) begin rd = 1'b1; cyc(H); rd = 1'b0; end
    end
    cyc(H);
    csn = 1'b1;
    cyc(3 * H);
  endtask

  task automatic rd_frame(input logic [4:0] st, input int nclk);
    status = st;
    csn = 1'b0; rd = 1'b1;
    cyc(2);
    check("R10 oe not yet at 2nd edge", {7'b0, sd_oe}, 8'h00);
    cyc(1);
    check("R10 oe at 3rd edge", {7'b0, sd_oe}, 8'h01);
    cyc(H);
    for (int i = 0; i < nclk; i++) begin
      check("R7 read bit", {7'b0, sd_o}, {7'b0, st[4-i]});
      sclk = 1'b1; cyc(H);
      sclk = 1'b0; cyc(H);
    end
    if (nclk == 5) check("R7 zero after five bits", {7'b0, sd_o}, 8'h00);
    check("R9 oe high in read frame", {7'b0, sd_oe}, 8'h01);
    status = ~st;
    csn = 1'b1; cyc(H);
    rd = 1'b0; cyc(3 * H);
    check("R9 sd_o low after read", {7'b0, sd_o}, 8'h00);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT && !finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<%0d cycles", cycles, WD_LIMIT);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    cyc(3);
    check("R1 cmd_o in reset", cmd, 8'h00);
    check("R1 strobe/oe/sd in reset", {5'b0, cmd_vld, sd_oe, sd_o}, 8'h00);
    rst_n = 1'b1;
    cyc(10);
    check("R1 cmd_o after reset", cmd, 8'h00);
    check("R1 strobe/oe/sd after reset", {5'b0, cmd_vld, sd_oe, sd_o}, 8'h00);

    wr_frame(9'h0A5, 8, 0, 0);
    check("R3 full write commits", cmd, 8'hA5);
    check("R2 first bit lands in bit 7", {7'b0, cmd[7]}, 8'h01);
    check("R3 one strobe", vld_seen[7:0], 8'd1);

    wr_frame(9'h03C, 7, 0, 0);
    check("R4 short write dropped", cmd, 8'hA5);
    check("R4 no strobe", vld_seen[7:0], 8'd1);

    wr_frame(9'h13C, 9, 0, 0);
    check("R5 long write dropped", cmd, 8'hA5);
    check("R5 no strobe", vld_seen[7:0], 8'd1);

    wr_frame(9'h0C3, 8, 1, 0);
    check("R6 direction flip drops frame", cmd, 8'hA5);
    check("R6 no strobe", vld_seen[7:0], 8'd1);

    wr_frame(9'h05A, 8, 0, 1);
    check("R11 last edge with cs rise counts", cmd, 8'h5A);
    check("R11 strobe", vld_seen[7:0], 8'd2);

    rd_frame(5'b10110, 5);
    rd_frame(5'b01101, 2);
    check("R8 truncated read harmless", cmd, 8'h5A);
    rd_frame(5'b11001, 5);
    rd_frame(5'b00001, 5);
    check("R12 reads leave cmd_o", cmd, 8'h5A);
    check("R12 reads raise no strobe", vld_seen[7:0], 8'd2);

    wr_frame(9'h081, 8, 0, 0);
    check("R2 bit order 0x81", cmd, 8'h81);
    check("R3 third strobe", vld_seen[7:0], 8'd3);

    cyc(10);
    finish_run();
  end
endmodule